// File: doc/BRIEF.md
# Edge-Detect Interrupt Latch Controller

This block captures edge events on up to 24 input lines, organised as three byte-wide banks, and turns them into a single interrupt request. Every line has its own edge-select bit and its own enable bit. When an enabled line shows the selected edge, a sticky status bit is set for that line. The status bit stays set until software clears it.

Software reaches the block through a small paged window. A 2-bit page number chooses the register kind: edge select, enable or status. A 2-bit offset chooses the bank. Write and read strobes carry the access. A byte-wide summary output flags which banks hold pending status. The interrupt request line is a registered OR of all status bits.

The line inputs must already be synchronised to the clock and must be true-level (not inverted).

Top module: `edge_irq_latch`

## Requirements
- R1: After synchronous reset, every edge-select, enable and status bit is 0, win_rdata is 0, pend_sum is 0 and irq_out is 0. An edge-select bit of 0 means falling edge.
- R2: Bit i of bank b stands for line 8*b+i. A write to page 1 stores the edge-select byte of bank `win_off`. A write to page 2 stores the enable byte. Reads of those pages return the stored byte. Page 0 and offset 3 hold nothing: writes there change no register and reads there return 0.
- R3: A line's level is sampled at each clock edge and compared with the level sampled at the edge before. An enabled line whose edge-select bit is 1 latches on a 0-to-1 change; one whose bit is 0 latches on a 1-to-0 change. The status bit (page 3) is set at the clock edge that samples the new level.
- R4: An edge of the opposite direction does not set the status bit, and neither does any edge on a disabled line.
- R5: A status bit that is set stays set through later line activity until it is cleared.
- R6: A write of any data to page 3 clears every status bit of the addressed bank only.
- R7: Writing 0 to an enable bit clears that line's status bit at the same clock edge. An enable write takes effect at that same edge.
- R8: If a clearing write and a qualifying edge fall on the same clock edge, the status bit of the edging line ends up set.
- R9: pend_sum bit k is 1 exactly when bank k has any status bit set. It follows the status bits combinationally. Bits 7 to 3 are always 0.
- R10: irq_out is 1 one clock after any status bit is 1, and 0 one clock after all status bits are 0.
- R11: When win_rd is 1 at a clock edge, win_rdata takes the value of the addressed register at that edge. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_wr | input | 1 | Write strobe for the register window |
| win_rd | input | 1 | Read strobe for the register window |
| win_page | input | 2 | Page: 1 edge select, 2 enable, 3 status |
| win_off | input | 2 | Bank offset, 0 to 2 |
| win_wdata | input | 8 | Write data |
| line_lvl | input | 24 | Synchronised true-level line inputs |
| win_rdata | output | 8 | Registered read data |
| pend_sum | output | 8 | Per-bank pending summary, bits 7 to 3 zero |
| irq_out | output | 1 | Registered interrupt request |

## Verification
Each of the 24 lines is swept with both edge-select values. In each case the line is driven through the wrong edge first and then the right one. This separates real direction selection from plain change detection, and it shows that each line maps to its own bank and bit. Broadcast edges on all lines at once, with a single-bank clear after them, show that clearing stays within one bank and that the summary flags the right banks. Directed collisions check the ordering rules: a clear and an edge on the same clock, and a disable landing on lines that are already pending. Writes to the unused page and offset check that nothing else is disturbed.

// File: rtl/eil_pkg.sv
package eil_pkg;

    typedef enum logic [1:0] {
        PG_NONE = 2'd0,
        PG_POL  = 2'd1,
        PG_EN   = 2'd2,
        PG_STAT = 2'd3
    } page_e;

    typedef struct packed {
        logic  wr;
        logic  rd;
        page_e page;
        logic [1:0] off;
    } win_cmd_t;

    // true when a command targets a given page and bank
    function automatic logic cmd_hits(input win_cmd_t c, input page_e pg, input int unsigned bank);
        return (c.page == pg) && (int'(c.off) == int'(bank));
    endfunction

    // qualify raw level changes against per-bit edge select
    function automatic logic [7:0] pick_edges(input logic [7:0] now_lvl,
                                              input logic [7:0] old_lvl,
                                              input logic [7:0] sel_rise);
        logic [7:0] rise;
        logic [7:0] fall;
        rise = now_lvl & ~old_lvl;
        fall = ~now_lvl & old_lvl;
        return (sel_rise & rise) | (~sel_rise & fall);
    endfunction

endpackage

// File: rtl/eil_decode.sv
module eil_decode
    import eil_pkg::*;
#(
    parameter int NUM_BANKS = 3
) (
    input  win_cmd_t             cmd,
    output logic [NUM_BANKS-1:0] pol_we,
    output logic [NUM_BANKS-1:0] en_we,
    output logic [NUM_BANKS-1:0] stat_clr
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
        always_comb begin
            pol_we[b]   = cmd.wr && cmd_hits(cmd, PG_POL,  b);
            en_we[b]    = cmd.wr && cmd_hits(cmd, PG_EN,   b);
            stat_clr[b] = cmd.wr && cmd_hits(cmd, PG_STAT, b);
        end
    end
endmodule

// File: rtl/eil_edge_det.sv
module eil_edge_det
    import eil_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] sel_rise,
    output logic [W-1:0] hit
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    always_comb hit = pick_edges(lvl, prev_q, sel_rise);
endmodule

// File: rtl/eil_bank.sv
module eil_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] wdata,
    input  logic         pol_we,
    input  logic         en_we,
    input  logic         stat_clr,
    output logic [W-1:0] pol_q,
    output logic [W-1:0] en_q,
    output logic [W-1:0] stat_q
);
    logic [W-1:0] hit;
    logic [W-1:0] en_next;
    logic [W-1:0] set_v;
    logic [W-1:0] clr_v;
    logic [W-1:0] stat_d;

    eil_edge_det #(.W(W)) u_det (
        .clk      (clk),
        .rst      (rst),
        .lvl      (lvl),
        .sel_rise (pol_q),
        .hit      (hit)
    );

    always_comb begin
        en_next = en_we ? wdata : en_q;
        set_v   = hit & en_next;
        clr_v   = {W{stat_clr}} | ~en_next;
        stat_d  = set_v | (stat_q & ~clr_v);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q  <= '0;
            en_q   <= '0;
            stat_q <= '0;
        end else begin
            if (pol_we) pol_q <= wdata;
            en_q   <= en_next;
            stat_q <= stat_d;
        end
    end
endmodule

// File: rtl/eil_readmux.sv
module eil_readmux
    import eil_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int W = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  win_cmd_t                    cmd,
    input  logic [NUM_BANKS-1:0][W-1:0] pol,
    input  logic [NUM_BANKS-1:0][W-1:0] en,
    input  logic [NUM_BANKS-1:0][W-1:0] stat,
    output logic [W-1:0]                rdata
);
    logic [W-1:0] sel;

    always_comb begin
        sel = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (int'(cmd.off) == b) begin
                unique case (cmd.page)
                    PG_POL:  sel = pol[b];
                    PG_EN:   sel = en[b];
                    PG_STAT: sel = stat[b];
                    default: sel = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata <= '0;
        else if (cmd.rd) rdata <= sel;
    end
endmodule

// File: rtl/edge_irq_latch.sv
module edge_irq_latch
    import eil_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int BANK_W = 8,
    localparam int LINES = NUM_BANKS * BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              win_wr,
    input  logic              win_rd,
    input  logic [1:0]        win_page,
    input  logic [1:0]        win_off,
    input  logic [BANK_W-1:0] win_wdata,
    input  logic [LINES-1:0]  line_lvl,
    output logic [BANK_W-1:0] win_rdata,
    output logic [BANK_W-1:0] pend_sum,
    output logic              irq_out
);
    win_cmd_t cmd;
    logic [NUM_BANKS-1:0] pol_we;
    logic [NUM_BANKS-1:0] en_we;
    logic [NUM_BANKS-1:0] stat_clr;
    logic [NUM_BANKS-1:0][BANK_W-1:0] pol_a;
    logic [NUM_BANKS-1:0][BANK_W-1:0] en_a;
    logic [NUM_BANKS-1:0][BANK_W-1:0] stat_a;
    logic [LINES-1:0] stat_flat;
    logic [LINES-1:0] en_flat;

    always_comb begin
        cmd.wr   = win_wr;
        cmd.rd   = win_rd;
        cmd.page = page_e'(win_page);
        cmd.off  = win_off;
    end

    eil_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
        .cmd      (cmd),
        .pol_we   (pol_we),
        .en_we    (en_we),
        .stat_clr (stat_clr)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        eil_bank #(.W(BANK_W)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .lvl      (line_lvl[b*BANK_W +: BANK_W]),
            .wdata    (win_wdata),
            .pol_we   (pol_we[b]),
            .en_we    (en_we[b]),
            .stat_clr (stat_clr[b]),
            .pol_q    (pol_a[b]),
            .en_q     (en_a[b]),
            .stat_q   (stat_a[b])
        );
        assign stat_flat[b*BANK_W +: BANK_W] = stat_a[b];
        assign en_flat[b*BANK_W +: BANK_W]   = en_a[b];
    end

    always_comb begin
        pend_sum = '0;
        for (int b = 0; b < NUM_BANKS; b++) pend_sum[b] = |stat_a[b];
    end

    always_ff @(posedge clk) begin
        if (rst) irq_out <= 1'b0;
        else     irq_out <= |stat_flat;
    end

    eil_readmux #(.NUM_BANKS(NUM_BANKS), .W(BANK_W)) u_rd (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .pol   (pol_a),
        .en    (en_a),
        .stat  (stat_a),
        .rdata (win_rdata)
    );
endmodule

// File: rtl/eil_checker.sv
module eil_checker #(
    parameter int LINES = 24,
    parameter int W = 8,
    parameter int NUM_BANKS = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             win_wr,
    input logic             win_rd,
    input logic [W-1:0]     win_rdata,
    input logic [W-1:0]     pend_sum,
    input logic             irq_out,
    input logic [LINES-1:0] stat_flat,
    input logic [LINES-1:0] en_flat
);
    AST_STAT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        (stat_flat & ~en_flat) == '0);  // R7

    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (rst)
        !win_wr |=> (($past(stat_flat) & ~stat_flat) == '0));  // R5

    AST_SUM_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        pend_sum[W-1:NUM_BANKS] == '0);  // R9

    AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_out == ($past(pend_sum) != '0)));  // R10

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !win_rd |=> $stable(win_rdata));  // R11
endmodule

bind edge_irq_latch eil_checker #(.LINES(LINES), .W(BANK_W), .NUM_BANKS(NUM_BANKS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .win_wr    (win_wr),
    .win_rd    (win_rd),
    .win_rdata (win_rdata),
    .pend_sum  (pend_sum),
    .irq_out   (irq_out),
    .stat_flat (stat_flat),
    .en_flat   (en_flat)
);

// File: tb/edge_irq_latch_test.sv
module edge_irq_latch_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        win_wr = 1'b0;
    logic        win_rd = 1'b0;
    logic [1:0]  win_page = 2'd0;
    logic [1:0]  win_off = 2'd0;
    logic [7:0]  win_wdata = 8'd0;
    logic [23:0] lines = 24'd0;
    logic [7:0]  win_rdata;
    logic [7:0]  pend_sum;
    logic        irq_out;

    int total = 0;
    int bad = 0;
    logic [7:0] got;

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_irq_latch uut (
        .clk       (clk),
        .rst       (rst),
        .win_wr    (win_wr),
        .win_rd    (win_rd),
        .win_page  (win_page),
        .win_off   (win_off),
        .win_wdata (win_wdata),
        .line_lvl  (lines),
        .win_rdata (win_rdata),
        .pend_sum  (pend_sum),
        .irq_out   (irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] pg, input logic [1:0] off, input logic [7:0] d);
        @(negedge clk);
        win_wr = 1'b1; win_page = pg; win_off = off; win_wdata = d;
        @(negedge clk);
        win_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] pg, input logic [1:0] off, output logic [7:0] v);
        @(negedge clk);
        win_rd = 1'b1; win_page = pg; win_off = off;
        @(negedge clk);
        win_rd = 1'b0;
        v = win_rdata;
    endtask

    task automatic drive(input logic [23:0] v);
        @(negedge clk);
        lines = v;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 rdata", win_rdata, 0);
        chk("R1 pend_sum", pend_sum, 0);
        chk("R1 irq", irq_out, 0);
        for (int pg = 1; pg < 4; pg++)
            for (int b = 0; b < 3; b++) begin
                rd(pg[1:0], b[1:0], got);
                chk("R1 reg", got, 0);
            end

        // R4 edges on disabled lines latch nothing
        drive(24'hFFFFFF);
        drive(24'h000000);
        for (int b = 0; b < 3; b++) begin
            rd(2'd3, b[1:0], got);
            chk("R4 disabled", got, 0);
        end
        chk("R4 irq", irq_out, 0);

        // per-line sweep with both edge selections
        for (int b = 0; b < 3; b++)
            for (int i = 0; i < 8; i++)
                for (int p = 0; p < 2; p++) begin
                    logic [7:0]  m;
                    logic [23:0] lb;
                    m  = 8'(1 << i);
                    lb = 24'(1) << (8 * b + i);
                    wr(2'd1, b[1:0], (p == 1) ? m : 8'h00);
                    drive((p == 1) ? lb : 24'h0);
                    wr(2'd2, b[1:0], m);
                    drive((p == 1) ? 24'h0 : lb);   // wrong direction
                    rd(2'd3, b[1:0], got);
                    chk("R4 wrong edge", got, 0);
                    drive((p == 1) ? lb : 24'h0);   // selected direction
                    chk("R9 sum", pend_sum, 8'(1 << b));
                    chk("R10 irq delayed", irq_out, 0);
                    rd(2'd3, b[1:0], got);
                    chk("R3 latch", got, m);
                    chk("R10 irq set", irq_out, 1);
                    drive((p == 1) ? 24'h0 : lb);
                    rd(2'd3, b[1:0], got);
                    chk("R5 sticky", got, m);
                    wr(2'd3, b[1:0], 8'h5A);
                    chk("R6 cleared sum", pend_sum, 0);
                    rd(2'd3, b[1:0], got);
                    chk("R6 clear", got, 0);
                    chk("R10 irq clear", irq_out, 0);
                    wr(2'd2, b[1:0], 8'h00);
                    drive(24'h0);
                    wr(2'd1, b[1:0], 8'h00);
                end

        // R6 clear limited to one bank, R9 full summary
        for (int b = 0; b < 3; b++) begin
            wr(2'd1, b[1:0], 8'hFF);
            wr(2'd2, b[1:0], 8'hFF);
        end
        drive(24'hFFFFFF);
        chk("R9 all banks", pend_sum, 8'h07);
        wr(2'd3, 2'd1, 8'h00);
        chk("R6 bank only", pend_sum, 8'h05);
        rd(2'd3, 2'd0, got); chk("R6 bank0 kept", got, 8'hFF);
        rd(2'd3, 2'd1, got); chk("R6 bank1 cleared", got, 8'h00);
        rd(2'd3, 2'd2, got); chk("R6 bank2 kept", got, 8'hFF);

        // R7 disabling clears pending status
        wr(2'd2, 2'd2, 8'h0F);
        rd(2'd3, 2'd2, got); chk("R7 disable clear", got, 8'h0F);
        rd(2'd2, 2'd2, got); chk("R7 enable readback", got, 8'h0F);
        wr(2'd3, 2'd0, 8'h00);
        wr(2'd3, 2'd2, 8'h00);
        drive(24'h000000);
        chk("R3 falling ignored with rise select", pend_sum, 0);

        // R8 clear and edge collide
        wr(2'd1, 2'd0, 8'h0A);
        wr(2'd2, 2'd0, 8'h0A);
        drive(24'h000002);
        rd(2'd3, 2'd0, got); chk("R8 setup", got, 8'h02);
        @(negedge clk);
        lines = 24'h00000A;
        win_wr = 1'b1; win_page = 2'd3; win_off = 2'd0; win_wdata = 8'hFF;
        @(negedge clk);
        win_wr = 1'b0;
        rd(2'd3, 2'd0, got); chk("R8 edge wins", got, 8'h08);
        wr(2'd3, 2'd0, 8'h00);

        // R2 unused page and offset
        wr(2'd1, 2'd0, 8'hAA);
        wr(2'd1, 2'd1, 8'h3C);
        wr(2'd0, 2'd0, 8'hFF);
        wr(2'd0, 2'd1, 8'hFF);
        wr(2'd1, 2'd3, 8'h55);
        wr(2'd2, 2'd3, 8'h55);
        rd(2'd1, 2'd0, got); chk("R2 pol0", got, 8'hAA);
        rd(2'd1, 2'd1, got); chk("R2 pol1", got, 8'h3C);
        rd(2'd1, 2'd2, got); chk("R2 pol2", got, 8'hFF);
        rd(2'd2, 2'd1, got); chk("R2 en1", got, 8'hFF);
        rd(2'd0, 2'd0, got); chk("R2 page0 read", got, 8'h00);
        rd(2'd1, 2'd3, got); chk("R2 off3 read", got, 8'h00);

        // R11 read data holds without a read strobe
        rd(2'd1, 2'd1, got);
        wr(2'd1, 2'd1, 8'h81);
        repeat (2) @(negedge clk);
        chk("R11 hold", win_rdata, 8'h3C);
        rd(2'd1, 2'd1, got); chk("R11 update", got, 8'h81);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule